// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block sits on the device side of an 8-bit parallel NAND flash bus. On every cycle where the bus write strobe `we` is high, it sorts the byte on `io` into one of three kinds. A command byte needs `ce_n` low and `cle` high. An address byte needs `ale` high. A data byte has both latch strobes low. Command bytes move a small state machine. Address bytes are packed into an address register, low byte first. When the right number of address bytes has arrived, the block sends a one-cycle start pulse to the engine for that operation. The storage array and the read data path are outside the block. They are driven from these pulses, from `start_col` and `erase_row`, and from the data strobe.

Two parameters select the geometry. `LARGE_PAGE` selects two column bytes and a 16-bit row shift; with it off, the block uses one column byte and an 8-bit shift. `BIG_PART` marks a large-page device of more than 1 Gbit, which needs five address bytes before an operation starts. `PAGE_BYTES` is the column where the spare area begins.

The state register holds the class of the last accepted command. Its states are:
- ST_READ, entered by 0x00, 0x01, 0x50 or 0xFF.
- ST_READID, entered by 0x90.
- ST_STATUS, entered by 0x70.
- ST_PROG, entered by 0x80.
- ST_COMMIT, entered by 0x10.
- ST_ERASE_SET, entered by 0x60.
- ST_ERASE_GO, entered by 0xD0.
- ST_RELOAD, entered by 0xE0 in large-page mode.
- ST_OTHER, entered by any other byte.

An accepted command byte always moves the state to the state its code names, except in two large-page cases. A 0x30 byte in ST_READ leaves every register unchanged. A 0x05 byte clears the column without changing the state. Reset returns the state to ST_READ.

Top module: `nand_cmd_seq`

## Requirements
- R1: When `we` is high, a byte is a command only if `ce_n`=0 and `cle`=1. It is an address byte if `ale`=1 and it is not a command. A byte with `cle`=0 and `ale`=0 while the last command is 0x80 pulses `data_take` for one cycle, with `data_byte`=`io`. With `ce_n`=1, a command byte changes nothing.
- R2: Address byte n (counting from 0) is written into `addr_q` bits 8n+7 down to 8n, and `addr_cnt` counts up to at most 5. Bytes that arrive after the fifth are dropped. Every accepted command clears `addr_cnt`, except 0xE0 and the large-page 0x30 case that is ignored.
- R3: 0x00 sets `col_offset` to 0, and 0x01 sets it to 0x100. 0x50 sets it to `PAGE_BYTES`. All three leave `cmd_code`=0x00. Every other accepted command is latched into `cmd_code` as it is, including unknown bytes.
- R4: In small-page mode, the third address byte after 0x00 pulses `go_read`, and the third address byte after 0x80 pulses `go_prog`.
- R5: In large-page mode, read and program start on the fourth address byte when `BIG_PART`=0 and on the fifth when `BIG_PART`=1.
- R6: After 0x90, the first address byte pulses `go_readid`.
- R7: 0x70 pulses `go_status`. `status_byte` is {`wp_n`, 1, 000000}: bit 7 shows the write-unprotected state and bit 6 shows ready.
- R8: When read or program starts, `start_col` equals the column bits of the address plus `col_offset`, and `col_offset` returns to 0.
- R9: These rules apply in large-page mode only. 0x30 after a read is ignored. 0x05 clears `addr_q[15:0]` and `addr_cnt`. 0xE0 pulses `go_reload` with `start_col` = `addr_q[15:0]`.
- R10: 0x10 pulses `go_commit`. 0xD0 pulses `go_erase`, with `erase_row` set to the address bytes received so far (higher bytes zeroed) shifted left by 8, or by 16 in large-page mode.
- R11: The `rst` input and the 0xFF command both return `cmd_code` to 0x00 and clear `addr_q`, `addr_cnt` and `col_offset`. `rst` also clears `start_col`, `erase_row`, `data_byte` and the pulses.
- R12: Every `go_*` output is a one-cycle pulse, and at most one of them is high in any cycle. An unrecognised command starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch strobe |
| ale | input | 1 | Address latch strobe |
| we | input | 1 | Bus write qualifier, one cycle per byte |
| wp_n | input | 1 | Write protect, active low |
| io | input | 8 | Bus byte |
| cmd_code | output | 8 | Last accepted command |
| addr_q | output | 40 | Collected address bytes |
| addr_cnt | output | 3 | Address bytes received |
| col_offset | output | 16 | Pending column offset |
| go_read | output | 1 | Read start pulse |
| go_readid | output | 1 | Identify start pulse |
| go_status | output | 1 | Status start pulse |
| go_prog | output | 1 | Program load start pulse |
| go_commit | output | 1 | Program commit pulse |
| go_erase | output | 1 | Erase start pulse |
| go_reload | output | 1 | Column reload pulse |
| start_col | output | 16 | Column for the started transfer |
| erase_row | output | 56 | Page address of the erase |
| data_take | output | 1 | Data byte accepted |
| data_byte | output | 8 | Accepted data byte |
| status_byte | output | 8 | Status value |

## Verification
The assertions assume that `cle` and `ale` are never both high on an accepted byte. They also assume that `we` lasts one cycle per bus byte. The stimulus drives one byte per cycle, with a single strobe raised for each byte. The one exception is a command attempt with `ce_n` high, which is used to show that the command is dropped. Three instances cover the small-page mode, large-page mode at 1 Gbit or less, and large-page mode above 1 Gbit. All three receive the same byte streams, including extra address bytes, ignored and unknown commands, and resets in the middle of a sequence.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_READID,
        ST_STATUS,
        ST_PROG,
        ST_COMMIT,
        ST_ERASE_SET,
        ST_ERASE_GO,
        ST_RELOAD,
        ST_OTHER
    } seq_state_t;

    typedef enum logic [1:0] {
        OFS_KEEP,
        OFS_ZERO,
        OFS_HALF,
        OFS_SPARE
    } ofs_sel_t;

    typedef struct packed {
        seq_state_t nxt;
        logic [7:0] code;
        ofs_sel_t   ofs;
        logic       keep_cnt;
        logic       ignore;
        logic       col_clr;
        logic       wipe;
    } cmd_dec_t;

    localparam logic [7:0] CB_READ       = 8'h00;
    localparam logic [7:0] CB_READ_HI    = 8'h01;
    localparam logic [7:0] CB_READ_SPARE = 8'h50;
    localparam logic [7:0] CB_READ_GO    = 8'h30;
    localparam logic [7:0] CB_COL_SET    = 8'h05;
    localparam logic [7:0] CB_COL_GO     = 8'hE0;
    localparam logic [7:0] CB_ID         = 8'h90;
    localparam logic [7:0] CB_STATUS     = 8'h70;
    localparam logic [7:0] CB_PROG       = 8'h80;
    localparam logic [7:0] CB_PROG_GO    = 8'h10;
    localparam logic [7:0] CB_ERASE      = 8'h60;
    localparam logic [7:0] CB_ERASE_GO   = 8'hD0;
    localparam logic [7:0] CB_RESET      = 8'hFF;

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
    import nand_seq_pkg::*;
#(
    parameter bit LARGE_PAGE = 1'b0
) (
    input  logic [7:0]  byte_in,
    input  seq_state_t  cur_state,
    output cmd_dec_t    dec
);

    always_comb begin
        dec          = '0;
        dec.nxt      = ST_OTHER;
        dec.code     = byte_in;
        dec.ofs      = OFS_KEEP;
        unique case (byte_in)
            CB_READ: begin
                dec.nxt = ST_READ;
                dec.ofs = OFS_ZERO;
            end
            CB_READ_HI: begin
                dec.nxt  = ST_READ;
                dec.ofs  = OFS_HALF;
                dec.code = CB_READ;
            end
            CB_READ_SPARE: begin
                dec.nxt  = ST_READ;
                dec.ofs  = OFS_SPARE;
                dec.code = CB_READ;
            end
            CB_RESET: begin
                dec.nxt  = ST_READ;
                dec.ofs  = OFS_ZERO;
                dec.code = CB_READ;
                dec.wipe = 1'b1;
            end
            CB_ID:       dec.nxt = ST_READID;
            CB_STATUS:   dec.nxt = ST_STATUS;
            CB_PROG:     dec.nxt = ST_PROG;
            CB_PROG_GO:  dec.nxt = ST_COMMIT;
            CB_ERASE:    dec.nxt = ST_ERASE_SET;
            CB_ERASE_GO: dec.nxt = ST_ERASE_GO;
            CB_COL_GO: begin
                dec.keep_cnt = 1'b1;
                dec.nxt      = LARGE_PAGE ? ST_RELOAD : ST_OTHER;
            end
            CB_READ_GO: begin
                if (LARGE_PAGE && cur_state == ST_READ) begin
                    dec.ignore = 1'b1;
                end
            end
            CB_COL_SET: begin
                if (LARGE_PAGE) begin
                    dec.col_clr = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nand_addr_collect.sv
module nand_addr_collect #(
    parameter int ADDR_BYTES = 5,
    parameter int COL_BYTES  = 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              take,
    input  logic [7:0]                        byte_in,
    input  logic                              clr_all,
    input  logic                              clr_cnt,
    input  logic                              clr_col,
    output logic [8*ADDR_BYTES-1:0]           addr_o,
    output logic [$clog2(ADDR_BYTES+1)-1:0]   cnt_o,
    output logic                              took_o
);

    localparam int CW = $clog2(ADDR_BYTES + 1);

    logic [CW-1:0] cnt_q;

    assign took_o = take && (cnt_q < CW'(ADDR_BYTES));
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_all || clr_cnt || clr_col) begin
            cnt_q <= '0;
        end else if (took_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        localparam bit IS_COL = (g < COL_BYTES);
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                lane_q <= '0;
            end else if (IS_COL && clr_col) begin
                lane_q <= '0;
            end else if (took_o && cnt_q == CW'(g)) begin
                lane_q <= byte_in;
            end
        end
        assign addr_o[g*8 +: 8] = lane_q;
    end

    // R2: the count never passes the number of address lanes
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(ADDR_BYTES));

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter bit LARGE_PAGE = 1'b0,
    parameter bit BIG_PART   = 1'b0,
    parameter int PAGE_BYTES = 512,
    parameter int ADDR_BYTES = 5
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             ce_n,
    input  logic                             cle,
    input  logic                             ale,
    input  logic                             we,
    input  logic                             wp_n,
    input  logic [7:0]                       io,
    output logic [7:0]                       cmd_code,
    output logic [8*ADDR_BYTES-1:0]          addr_q,
    output logic [$clog2(ADDR_BYTES+1)-1:0]  addr_cnt,
    output logic [15:0]                      col_offset,
    output logic                             go_read,
    output logic                             go_readid,
    output logic                             go_status,
    output logic                             go_prog,
    output logic                             go_commit,
    output logic                             go_erase,
    output logic                             go_reload,
    output logic [15:0]                      start_col,
    output logic [8*ADDR_BYTES+15:0]         erase_row,
    output logic                             data_take,
    output logic [7:0]                       data_byte,
    output logic [7:0]                       status_byte
);

    localparam int ADDR_W    = 8 * ADDR_BYTES;
    localparam int ROW_W     = ADDR_W + 16;
    localparam int CW        = $clog2(ADDR_BYTES + 1);
    localparam int COL_BYTES = LARGE_PAGE ? 2 : 1;
    localparam int COL_W     = 8 * COL_BYTES;
    localparam int TRIG      = LARGE_PAGE ? (BIG_PART ? 5 : 4) : 3;
    localparam int ERASE_SH  = LARGE_PAGE ? 16 : 8;

    seq_state_t  state;
    cmd_dec_t    dec;
    logic        cmd_take, adr_take, dat_take, act, took, trig_hit;
    logic [15:0] col_now;
    logic [ADDR_W-1:0] masked;

    assign cmd_take = we && !ce_n && cle;
    assign adr_take = we && ale && !cmd_take;
    assign dat_take = we && !cle && !ale && (state == ST_PROG);
    assign act      = cmd_take && !dec.ignore && !dec.col_clr;
    assign trig_hit = took && (addr_cnt == CW'(TRIG - 1));
    assign col_now  = 16'(addr_q[COL_W-1:0]);
    assign status_byte = {wp_n, 1'b1, 6'b000000};

    always_comb begin
        for (int i = 0; i < ADDR_BYTES; i++) begin
            masked[i*8 +: 8] = (CW'(i) < addr_cnt) ? addr_q[i*8 +: 8] : 8'h00;
        end
    end

    nand_cmd_decode #(.LARGE_PAGE(LARGE_PAGE)) u_dec (
        .byte_in   (io),
        .cur_state (state),
        .dec       (dec)
    );

    nand_addr_collect #(.ADDR_BYTES(ADDR_BYTES), .COL_BYTES(COL_BYTES)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .take    (adr_take),
        .byte_in (io),
        .clr_all (act && dec.wipe),
        .clr_cnt (act && !dec.keep_cnt),
        .clr_col (cmd_take && dec.col_clr),
        .addr_o  (addr_q),
        .cnt_o   (addr_cnt),
        .took_o  (took)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_READ;
        end else if (act) begin
            state <= dec.nxt;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_code   <= CB_READ;
            col_offset <= '0;
            go_read    <= 1'b0;
            go_readid  <= 1'b0;
            go_status  <= 1'b0;
            go_prog    <= 1'b0;
            go_commit  <= 1'b0;
            go_erase   <= 1'b0;
            go_reload  <= 1'b0;
            start_col  <= '0;
            erase_row  <= '0;
            data_take  <= 1'b0;
            data_byte  <= '0;
        end else begin
            go_read   <= 1'b0;
            go_readid <= 1'b0;
            go_status <= 1'b0;
            go_prog   <= 1'b0;
            go_commit <= 1'b0;
            go_erase  <= 1'b0;
            go_reload <= 1'b0;
            data_take <= 1'b0;
            if (act) begin
                cmd_code <= dec.code;
                unique case (dec.ofs)
                    OFS_ZERO:  col_offset <= '0;
                    OFS_HALF:  col_offset <= 16'h0100;
                    OFS_SPARE: col_offset <= 16'(PAGE_BYTES);
                    OFS_KEEP:  ;
                endcase
                unique case (dec.nxt)
                    ST_STATUS:   go_status <= 1'b1;
                    ST_COMMIT:   go_commit <= 1'b1;
                    ST_ERASE_GO: begin
                        go_erase  <= 1'b1;
                        erase_row <= ROW_W'(masked) << ERASE_SH;
                    end
                    ST_RELOAD: begin
                        go_reload <= 1'b1;
                        start_col <= col_now;
                    end
                    default: ;
                endcase
            end
            if (took) begin
                unique case (state)
                    ST_READID: if (addr_cnt == '0) go_readid <= 1'b1;
                    ST_READ: if (trig_hit) begin
                        go_read    <= 1'b1;
                        start_col  <= col_now + col_offset;
                        col_offset <= '0;
                    end
                    ST_PROG: if (trig_hit) begin
                        go_prog    <= 1'b1;
                        start_col  <= col_now + col_offset;
                        col_offset <= '0;
                    end
                    default: ;
                endcase
            end
            if (dat_take) begin
                data_take <= 1'b1;
                data_byte <= io;
            end
        end
    end

    // R12: never more than one start pulse at a time
    assert_one_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({go_read, go_readid, go_status, go_prog, go_commit, go_erase, go_reload}));

    // R6: identify starts exactly when the first address byte has landed
    assert_id_first_R6: assert property (@(posedge clk) disable iff (rst)
        go_readid |-> addr_cnt == CW'(1));

    // R4 and R5: transfers start on the mode's trigger byte count
    assert_trig_cnt_R4: assert property (@(posedge clk) disable iff (rst)
        (go_read || go_prog) |-> addr_cnt == CW'(TRIG));

    // R2: a counted command leaves the address count at zero
    assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_take && !dec.ignore && !dec.keep_cnt) |=> addr_cnt == '0);

    // R8: the offset is consumed when a transfer starts
    assert_ofs_used_R8: assert property (@(posedge clk) disable iff (rst)
        (go_read || go_prog) |-> col_offset == '0);

endmodule

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 3;

    logic clk = 1'b0;
    logic rst = 1'b1, ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we = 1'b0, wp_n = 1'b1;
    logic [7:0] io = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0]  o_cmd [NI];
    logic [39:0] o_addr [NI];
    logic [2:0]  o_cnt [NI];
    logic [15:0] o_off [NI];
    logic [6:0]  o_pul [NI];
    logic [15:0] o_scol [NI];
    logic [55:0] o_erow [NI];
    logic        o_dt [NI];
    logic [7:0]  o_db [NI];
    logic [7:0]  o_st [NI];

    nand_cmd_seq dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we(we), .wp_n(wp_n), .io(io),
        .cmd_code(o_cmd[0]), .addr_q(o_addr[0]), .addr_cnt(o_cnt[0]), .col_offset(o_off[0]),
        .go_read(o_pul[0][6]), .go_readid(o_pul[0][5]), .go_status(o_pul[0][4]),
        .go_prog(o_pul[0][3]), .go_commit(o_pul[0][2]), .go_erase(o_pul[0][1]),
        .go_reload(o_pul[0][0]), .start_col(o_scol[0]), .erase_row(o_erow[0]),
        .data_take(o_dt[0]), .data_byte(o_db[0]), .status_byte(o_st[0]));

    nand_cmd_seq #(.LARGE_PAGE(1'b1), .BIG_PART(1'b0), .PAGE_BYTES(2048)) dut_lpa (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we(we), .wp_n(wp_n), .io(io),
        .cmd_code(o_cmd[1]), .addr_q(o_addr[1]), .addr_cnt(o_cnt[1]), .col_offset(o_off[1]),
        .go_read(o_pul[1][6]), .go_readid(o_pul[1][5]), .go_status(o_pul[1][4]),
        .go_prog(o_pul[1][3]), .go_commit(o_pul[1][2]), .go_erase(o_pul[1][1]),
        .go_reload(o_pul[1][0]), .start_col(o_scol[1]), .erase_row(o_erow[1]),
        .data_take(o_dt[1]), .data_byte(o_db[1]), .status_byte(o_st[1]));

    nand_cmd_seq #(.LARGE_PAGE(1'b1), .BIG_PART(1'b1), .PAGE_BYTES(2048)) dut_lpb (
        .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we(we), .wp_n(wp_n), .io(io),
        .cmd_code(o_cmd[2]), .addr_q(o_addr[2]), .addr_cnt(o_cnt[2]), .col_offset(o_off[2]),
        .go_read(o_pul[2][6]), .go_readid(o_pul[2][5]), .go_status(o_pul[2][4]),
        .go_prog(o_pul[2][3]), .go_commit(o_pul[2][2]), .go_erase(o_pul[2][1]),
        .go_reload(o_pul[2][0]), .start_col(o_scol[2]), .erase_row(o_erow[2]),
        .data_take(o_dt[2]), .data_byte(o_db[2]), .status_byte(o_st[2]));

    // reference model state
    int lp  [NI] = '{0, 1, 1};
    int big [NI] = '{0, 0, 1};
    int pg  [NI] = '{512, 2048, 2048};
    logic [7:0]  e_cmd [NI];
    longint      e_addr [NI];
    int          e_cnt [NI];
    int          e_off [NI];
    logic [6:0]  e_pul [NI];
    int          e_scol [NI];
    longint      e_erow [NI];
    logic        e_dt [NI];
    logic [7:0]  e_db [NI];

    int n_cmp = 0, n_bad = 0;
    bit armed = 0;
    string note = "R11";

    task automatic chk(input string tag, input int m, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s inst%0d actual=%h expected=%h", tag, m, act, exp);
        end
    endtask

    function automatic void mstep(int m);
        logic [7:0] v;
        longint cmask;
        int trig, sh;
        cmask = lp[m] ? 64'hFFFF : 64'hFF;
        trig  = lp[m] ? (big[m] ? 5 : 4) : 3;
        sh    = lp[m] ? 16 : 8;
        e_pul[m] = '0;
        e_dt[m]  = 1'b0;
        if (rst) begin
            e_cmd[m] = 8'h00; e_addr[m] = 0; e_cnt[m] = 0; e_off[m] = 0;
            e_scol[m] = 0; e_erow[m] = 0; e_db[m] = 8'h00;
            return;
        end
        if (!we) return;
        if (!ce_n && cle) begin
            if (lp[m] != 0 && e_cmd[m] == 8'h00 && io == 8'h30) begin
            end else if (lp[m] != 0 && io == 8'h05) begin
                e_addr[m] = e_addr[m] & ~cmask;
                e_cnt[m] = 0;
            end else begin
                v = io;
                if (v == 8'h00) e_off[m] = 0;
                else if (v == 8'h01) begin e_off[m] = 256; v = 8'h00; end
                else if (v == 8'h50) begin e_off[m] = pg[m]; v = 8'h00; end
                if (v == 8'h70) e_pul[m][4] = 1'b1;
                if (v == 8'h10) e_pul[m][2] = 1'b1;
                if (v == 8'hD0) begin
                    e_pul[m][1] = 1'b1;
                    e_erow[m] = (e_addr[m] & ((64'h1 << (8 * e_cnt[m])) - 1)) << sh;
                end
                if (v == 8'hE0 && lp[m] != 0) begin
                    e_pul[m][0] = 1'b1;
                    e_scol[m] = int'(e_addr[m] & cmask);
                end
                if (v == 8'hFF) begin v = 8'h00; e_addr[m] = 0; e_off[m] = 0; end
                if (io != 8'hE0) e_cnt[m] = 0;
                e_cmd[m] = v;
            end
        end else if (ale) begin
            if (e_cnt[m] < 5) begin
                e_addr[m] = (e_addr[m] & ~(64'hFF << (8 * e_cnt[m]))) | (longint'(io) << (8 * e_cnt[m]));
                e_cnt[m]++;
                if (e_cmd[m] == 8'h90 && e_cnt[m] == 1) e_pul[m][5] = 1'b1;
                if ((e_cmd[m] == 8'h00 || e_cmd[m] == 8'h80) && e_cnt[m] == trig) begin
                    if (e_cmd[m] == 8'h00) e_pul[m][6] = 1'b1; else e_pul[m][3] = 1'b1;
                    e_scol[m] = int'(((e_addr[m] & cmask) + e_off[m]) & 64'hFFFF);
                    e_off[m] = 0;
                end
            end
        end
        if (!cle && !ale && e_cmd[m] == 8'h80) begin
            e_dt[m] = 1'b1;
            e_db[m] = io;
        end
    endfunction

    task automatic compare_all();
        for (int m = 0; m < NI; m++) begin
            chk(note, m, 64'(o_cmd[m]), 64'(e_cmd[m]));
            chk("R2", m, 64'(o_addr[m]), 64'(e_addr[m]));
            chk("R2", m, 64'(o_cnt[m]), 64'(e_cnt[m]));
            chk("R3", m, 64'(o_off[m]), 64'(e_off[m] & 16'hFFFF));
            chk(m == 0 ? "R4" : "R5", m, 64'(o_pul[m][6]), 64'(e_pul[m][6]));
            chk("R6", m, 64'(o_pul[m][5]), 64'(e_pul[m][5]));
            chk("R7", m, 64'(o_pul[m][4]), 64'(e_pul[m][4]));
            chk(m == 0 ? "R4" : "R5", m, 64'(o_pul[m][3]), 64'(e_pul[m][3]));
            chk("R10", m, 64'(o_pul[m][2]), 64'(e_pul[m][2]));
            chk("R10", m, 64'(o_pul[m][1]), 64'(e_pul[m][1]));
            chk("R9", m, 64'(o_pul[m][0]), 64'(e_pul[m][0]));
            chk("R12", m, 64'($countones(o_pul[m]) <= 1), 64'(1));
            chk("R8", m, 64'(o_scol[m]), 64'(e_scol[m] & 16'hFFFF));
            chk("R10", m, 64'(o_erow[m]), 64'(e_erow[m]));
            chk("R1", m, 64'(o_dt[m]), 64'(e_dt[m]));
            chk("R1", m, 64'(o_db[m]), 64'(e_db[m]));
            chk("R7", m, 64'(o_st[m]), 64'({wp_n, 1'b1, 6'b0}));
        end
    endtask

    task automatic tick(input logic r, input logic c_n, input logic cl, input logic al,
                        input logic w, input logic [7:0] d);
        @(negedge clk);
        if (armed) compare_all();
        armed = 1;
        rst = r; ce_n = c_n; cle = cl; ale = al; we = w; io = d;
        for (int m = 0; m < NI; m++) mstep(m);
    endtask

    task automatic cmd_b(input logic [7:0] b); tick(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, b); endtask
    task automatic adr_b(input logic [7:0] b); tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, b); endtask
    task automatic dat_b(input logic [7:0] b); tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, b); endtask
    task automatic idle();                     tick(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00); endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R11: reset state
        note = "R11";
        tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        idle();
        // R4 R5: plain read, trigger counts per mode, extra bytes saturate (R2)
        note = "R3";
        cmd_b(8'h00); adr_b(8'h12); adr_b(8'h34); adr_b(8'h56); adr_b(8'h78); adr_b(8'h9A);
        adr_b(8'hBC); idle();
        // R3 R8: second-half and spare reads move the column
        cmd_b(8'h01); adr_b(8'h10); adr_b(8'h02); adr_b(8'h03); adr_b(8'h04); adr_b(8'h05); idle();
        cmd_b(8'h50); adr_b(8'h07); adr_b(8'h01); adr_b(8'h02); adr_b(8'h03); adr_b(8'h04); idle();
        // R6: identify
        cmd_b(8'h90); adr_b(8'h00); adr_b(8'h00); idle();
        // R7: status with protection toggled
        cmd_b(8'h70); idle();
        wp_n = 1'b0; idle(); idle();
        wp_n = 1'b1; idle();
        // R1: program with data, commit (R10)
        cmd_b(8'h80); adr_b(8'h20); adr_b(8'h01); adr_b(8'h11); adr_b(8'h22); adr_b(8'h33);
        dat_b(8'hA5); dat_b(8'h5A); idle(); dat_b(8'h3C); cmd_b(8'h10); idle();
        // R1: command with chip disabled is dropped; data outside program ignored
        tick(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h70); dat_b(8'h77); idle();
        // R10: erase with three and with two row bytes
        cmd_b(8'h60); adr_b(8'h45); adr_b(8'h67); adr_b(8'h89); cmd_b(8'hD0); idle();
        cmd_b(8'h60); adr_b(8'hAA); adr_b(8'hBB); cmd_b(8'hD0); idle();
        // R9: large-page confirm ignored, column change and reload
        note = "R9";
        cmd_b(8'h00); adr_b(8'h40); adr_b(8'h03); adr_b(8'h05); adr_b(8'h06); adr_b(8'h07);
        cmd_b(8'h30); idle();
        cmd_b(8'h05); adr_b(8'h80); adr_b(8'h01); cmd_b(8'hE0); idle();
        adr_b(8'h09); idle();
        // R12: unknown command latched, starts nothing
        note = "R12";
        cmd_b(8'hAB); adr_b(8'h01); adr_b(8'h02); adr_b(8'h03); adr_b(8'h04); adr_b(8'h05); idle();
        // R11: reset command and reset input in mid sequence
        note = "R11";
        cmd_b(8'h01); adr_b(8'h11); adr_b(8'h22); cmd_b(8'hFF); idle();
        adr_b(8'h01); adr_b(8'h02); adr_b(8'h03); idle();
        cmd_b(8'h50); adr_b(8'h33);
        tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        idle(); idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule